// File: doc/BRIEF.md
# Dynamic-Priority Interrupt Winner Selector

This block picks one interrupt line out of up to three banks of 32 lines. Each line brings a pending bit, a mask bit, a routing bit that assigns it to the fast class or the normal class, and a 5-bit urgency value. For the class named on `class_sel_i`, a combinational reduction tree finds the most urgent eligible line. A one-cycle `capture_i` strobe then stores that line's global number in the capture register of that class.

Each class has its own capture register and its own small state machine with two named states. `HOLD_EMPTY` means the last capture found no candidate. `HOLD_VALID` means the stored code names a real line. On reset both machines enter `HOLD_EMPTY`. A capture strobe for a class moves that class's machine to `HOLD_VALID` if a candidate exists (transition "capture-hit") and to `HOLD_EMPTY` if none exists (transition "capture-miss"). With no strobe for the class, the machine keeps its state (transition "hold"). The `found_*` outputs are decoded from the state. Registering bank contents, sensing inputs and signalling the processor are left to neighbouring logic.

Top module: `irq_winner_sel`

## Requirements
- R1: A line takes part only when its pending bit is 1, its mask bit is 0, and its routing bit equals the class being arbitrated (`class_sel_i` 1 = fast, 0 = normal). A line that is masked or routed to the other class never wins, whatever its urgency.
- R2: Among eligible lines, the one with the smallest 5-bit urgency value wins. Line k's value is `prio_i[5k+4:5k]`, and 0 is the most urgent value.
- R3: When several eligible lines share the smallest value, the one with the highest global number wins.
- R4: The code reported is 32 × bank + line within the bank. Global line k is bit k of `pend_i`, `mask_i` and `route_i`.
- R5: When no line is eligible at a capture, the captured code is 0 and the class's found flag is 0. A capture of line 0 sets the flag to 1.
- R6: Only the NUM_BANKS banks (1 to 3) take part. A found code is always below NUM_BANKS × 32.
- R7: A capture register and its flag change only on the clock edge where `capture_i` is 1 and `class_sel_i` names that class. Otherwise they hold, even while the inputs change.
- R8: A capture for one class leaves the other class's code and flag unchanged.
- R9: After reset both codes are 0 and both found flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pend_i | input | NUM_BANKS*32 | Pending bit per global line |
| mask_i | input | NUM_BANKS*32 | Mask bit per line, 0 = enabled |
| route_i | input | NUM_BANKS*32 | Class routing per line, 1 = fast |
| prio_i | input | NUM_BANKS*32*5 | Urgency per line, 0 most urgent |
| class_sel_i | input | 1 | Class to arbitrate, 1 = fast |
| capture_i | input | 1 | One-cycle capture strobe |
| code_fast_o | output | 7 | Captured fast-class line code |
| found_fast_o | output | 1 | Fast capture found a candidate |
| code_norm_o | output | 7 | Captured normal-class line code |
| found_norm_o | output | 1 | Normal capture found a candidate |

## Verification
On every cycle the assertions check four things. A cleared flag comes with a zero code. A set flag comes with a code inside the active banks that names a line eligible for that class at the capture edge. A flag after a capture matches whether any line was eligible. A register without its own strobe stays put. The ordering rules cannot be seen by those properties: lower value beats higher, ties go to the higher line, and the bank offset is added into the code. Only the bench's vector table, its directed cases and its random comparison against a reference scan show them.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
    localparam int LINES_PER_BANK = 32;
    localparam int MAX_BANKS      = 3;
    localparam int PRIO_W         = 5;
    localparam int CODE_W         = $clog2(MAX_BANKS * LINES_PER_BANK);

    typedef enum logic {
        CLS_NORMAL = 1'b0,
        CLS_FAST   = 1'b1
    } irq_class_e;

    typedef enum logic {
        HOLD_EMPTY = 1'b0,
        HOLD_VALID = 1'b1
    } hold_state_e;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [CODE_W-1:0] code;
    } sel_node_t;
endpackage

// File: rtl/irq_sel_eligible.sv
module irq_sel_eligible #(
    parameter int N = 96
) (
    input  logic [N-1:0] pend_i,
    input  logic [N-1:0] mask_i,
    input  logic [N-1:0] route_i,
    input  logic         class_i,
    output logic [N-1:0] elig_o
);
    for (genvar k = 0; k < N; k++) begin : g_line
        assign elig_o[k] = pend_i[k] & ~mask_i[k] & (route_i[k] == class_i);
    end
endmodule

// File: rtl/irq_sel_tree.sv
module irq_sel_tree
    import irq_sel_pkg::*;
#(
    parameter int N = 96
) (
    input  logic [N-1:0]        elig_i,
    input  logic [N*PRIO_W-1:0] prio_i,
    output sel_node_t           win_o
);
    localparam int LVL   = (N > 1) ? $clog2(N) : 1;
    localparam int P     = 1 << LVL;
    localparam int NODES = 2 * P - 1;

    sel_node_t node [NODES];

    // Leaves sit left to right in ascending line order.
    for (genvar k = 0; k < P; k++) begin : g_leaf
        if (k < N) begin : g_real
            assign node[P-1+k] = '{valid: elig_i[k],
                                   prio:  prio_i[k*PRIO_W +: PRIO_W],
                                   code:  CODE_W'(k)};
        end else begin : g_pad
            assign node[P-1+k] = '{valid: 1'b0, prio: '1, code: '0};
        end
    end

    // The right child covers higher lines, so it takes equal urgency.
    for (genvar i = 0; i < P - 1; i++) begin : g_node
        logic take_right;
        assign take_right = node[2*i+2].valid &&
                            (!node[2*i+1].valid || (node[2*i+2].prio <= node[2*i+1].prio));
        assign node[i] = take_right ? node[2*i+2] : node[2*i+1];
    end

    assign win_o = node[0];
endmodule

// File: rtl/irq_sel_capture.sv
module irq_sel_capture
    import irq_sel_pkg::*;
#(
    parameter irq_class_e MY_CLASS = CLS_NORMAL
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture_i,
    input  logic              class_i,
    input  sel_node_t         win_i,
    output logic [CODE_W-1:0] code_o,
    output logic              found_o
);
    hold_state_e       state_q, state_d;
    logic [CODE_W-1:0] code_q, code_d;
    logic              fire;

    assign fire = capture_i && (class_i == MY_CLASS);

    always_comb begin
        state_d = state_q;
        code_d  = code_q;
        if (fire) begin
            unique case (win_i.valid)
                1'b1: begin
                    state_d = HOLD_VALID;
                    code_d  = win_i.code;
                end
                1'b0: begin
                    state_d = HOLD_EMPTY;
                    code_d  = '0;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= HOLD_EMPTY;
            code_q  <= '0;
        end else begin
            state_q <= state_d;
            code_q  <= code_d;
        end
    end

    always_comb begin
        unique case (state_q)
            HOLD_VALID: found_o = 1'b1;
            HOLD_EMPTY: found_o = 1'b0;
            default:    found_o = 1'b0;
        endcase
        code_o = code_q;
    end
endmodule

// File: rtl/irq_winner_sel.sv
module irq_winner_sel
    import irq_sel_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    localparam int N = NUM_BANKS * LINES_PER_BANK
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [N-1:0]        pend_i,
    input  logic [N-1:0]        mask_i,
    input  logic [N-1:0]        route_i,
    input  logic [N*PRIO_W-1:0] prio_i,
    input  logic                class_sel_i,
    input  logic                capture_i,
    output logic [CODE_W-1:0]   code_fast_o,
    output logic                found_fast_o,
    output logic [CODE_W-1:0]   code_norm_o,
    output logic                found_norm_o
);
    logic [N-1:0] elig;
    sel_node_t    win;

    irq_sel_eligible #(.N(N)) u_elig (
        .pend_i  (pend_i),
        .mask_i  (mask_i),
        .route_i (route_i),
        .class_i (class_sel_i),
        .elig_o  (elig)
    );

    irq_sel_tree #(.N(N)) u_tree (
        .elig_i (elig),
        .prio_i (prio_i),
        .win_o  (win)
    );

    irq_sel_capture #(.MY_CLASS(CLS_FAST)) u_cap_fast (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture_i),
        .class_i   (class_sel_i),
        .win_i     (win),
        .code_o    (code_fast_o),
        .found_o   (found_fast_o)
    );

    irq_sel_capture #(.MY_CLASS(CLS_NORMAL)) u_cap_norm (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture_i),
        .class_i   (class_sel_i),
        .win_i     (win),
        .code_o    (code_norm_o),
        .found_o   (found_norm_o)
    );
endmodule

// File: rtl/irq_winner_sel_chk.sv
module irq_winner_sel_chk
    import irq_sel_pkg::*;
#(
    parameter int NUM_BANKS = 3,
    localparam int N = NUM_BANKS * LINES_PER_BANK
) (
    input logic                clk,
    input logic                rst_n,
    input logic [N-1:0]        pend_i,
    input logic [N-1:0]        mask_i,
    input logic [N-1:0]        route_i,
    input logic [N*PRIO_W-1:0] prio_i,
    input logic                class_sel_i,
    input logic                capture_i,
    input logic [CODE_W-1:0]   code_fast_o,
    input logic                found_fast_o,
    input logic [CODE_W-1:0]   code_norm_o,
    input logic                found_norm_o
);
    logic [N-1:0] ok_fast, ok_norm;
    logic         cap_fast, cap_norm;
    logic         prio_seen;

    assign ok_fast   = pend_i & ~mask_i & route_i;
    assign ok_norm   = pend_i & ~mask_i & ~route_i;
    assign cap_fast  = capture_i && class_sel_i;
    assign cap_norm  = capture_i && !class_sel_i;
    assign prio_seen = ^prio_i;

    assert_empty_zero_fast_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !found_fast_o |-> code_fast_o == '0);
    assert_empty_zero_norm_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !found_norm_o |-> code_norm_o == '0);

    assert_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (found_fast_o |-> 32'(code_fast_o) < N) and (found_norm_o |-> 32'(code_norm_o) < N));

    assert_flag_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fast |=> found_fast_o == $past(|ok_fast));
    assert_flag_norm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_norm |=> found_norm_o == $past(|ok_norm));

    assert_winner_eligible_fast_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_fast |=> (!found_fast_o || (($past(ok_fast) >> code_fast_o) & N'(1)) != '0));
    assert_winner_eligible_norm_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cap_norm |=> (!found_norm_o || (($past(ok_norm) >> code_norm_o) & N'(1)) != '0));

    assert_hold_fast_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_fast |=> $stable(code_fast_o) && $stable(found_fast_o));
    assert_hold_norm_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_norm |=> $stable(code_norm_o) && $stable(found_norm_o));

    always_comb begin
        if (rst_n && $isunknown(prio_seen)) begin
            assert (1'b0) else $error("urgency input unknown");
        end
    end
endmodule

bind irq_winner_sel irq_winner_sel_chk #(.NUM_BANKS(NUM_BANKS)) u_chk (.*);

// File: tb/tb_irq_winner_sel.sv
module tb_irq_winner_sel;
    import irq_sel_pkg::*;

    localparam int NB = 3;
    localparam int N  = NB * LINES_PER_BANK;

    logic                clk = 1'b0;
    logic                rst_n = 1'b0;
    logic [N-1:0]        pend, mask, route;
    logic [N*PRIO_W-1:0] prio;
    logic                class_sel, capture;
    logic [CODE_W-1:0]   code_fast, code_norm;
    logic                found_fast, found_norm;

    int n_checks = 0;
    int n_fail   = 0;
    bit timed_out = 1'b0;

    always #2 clk = ~clk;

    irq_winner_sel #(.NUM_BANKS(NB)) dut (
        .clk(clk), .rst_n(rst_n), .pend_i(pend), .mask_i(mask), .route_i(route),
        .prio_i(prio), .class_sel_i(class_sel), .capture_i(capture),
        .code_fast_o(code_fast), .found_fast_o(found_fast),
        .code_norm_o(code_norm), .found_norm_o(found_norm)
    );

    // Vector table: two pending lines (-1 = none), both routed to the class.
    localparam int NV = 8;
    localparam int TV_LA  [NV] = '{ 5,  5, 95, 33, -1, 64,  0, 10};
    localparam int TV_PA  [NV] = '{ 3,  2,  0, 31,  0,  1,  0,  9};
    localparam int TV_LB  [NV] = '{40, 70,  0, -1, -1, 63, -1, 11};
    localparam int TV_PB  [NV] = '{ 7,  2,  0,  0,  0,  4,  0,  8};
    localparam int TV_CLS [NV] = '{ 1,  0,  1,  0,  1,  0,  1,  1};
    localparam int TV_EXP [NV] = '{ 5, 70, 95, 33,  0, 64,  0, 11};
    localparam int TV_FND [NV] = '{ 1,  1,  1,  1,  0,  1,  1,  1};

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_inputs();
        pend  = '0;
        mask  = '0;
        route = '0;
        prio  = '1;
    endtask

    task automatic set_prio(input int line, input int p);
        prio[line*PRIO_W +: PRIO_W] = PRIO_W'(p);
    endtask

    // Strobe on one edge; outputs are sampled at the following falling edge.
    task automatic do_capture(input bit cls);
        class_sel = cls;
        capture   = 1'b1;
        @(negedge clk);
        capture   = 1'b0;
    endtask

    task automatic ref_pick(input bit cls, output bit fnd, output int code);
        int best = 99;
        fnd  = 1'b0;
        code = 0;
        for (int i = 0; i < N; i++) begin
            if (pend[i] && !mask[i] && route[i] == cls) begin
                if (int'(prio[i*PRIO_W +: PRIO_W]) <= best) begin
                    best = int'(prio[i*PRIO_W +: PRIO_W]);
                    code = i;
                    fnd  = 1'b1;
                end
            end
        end
    endtask

    task automatic check_class(input string req, input bit cls, input int exp, input bit fnd);
        if (cls) begin
            check(req, int'(code_fast), exp);
            check(req, int'(found_fast), int'(fnd));
        end else begin
            check(req, int'(code_norm), exp);
            check(req, int'(found_norm), int'(fnd));
        end
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        timed_out = 1'b1;
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin : stim
        bit  rf;
        int  rc;
        int  saved_c;
        bit  saved_f;
        clear_inputs();
        class_sel = 1'b0;
        capture   = 1'b0;
        repeat (3) @(negedge clk);
        // R9: reset state
        check("R9 code_fast", int'(code_fast), 0);
        check("R9 found_fast", int'(found_fast), 0);
        check("R9 code_norm", int'(code_norm), 0);
        check("R9 found_norm", int'(found_norm), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // Table walk: R2 (rows 0,5,7), R3 (rows 1,2), R4 (rows 3,5), R5 (rows 4,6)
        for (int v = 0; v < NV; v++) begin
            clear_inputs();
            if (TV_LA[v] >= 0) begin
                pend[TV_LA[v]]  = 1'b1;
                route[TV_LA[v]] = TV_CLS[v][0];
                set_prio(TV_LA[v], TV_PA[v]);
            end
            if (TV_LB[v] >= 0) begin
                pend[TV_LB[v]]  = 1'b1;
                route[TV_LB[v]] = TV_CLS[v][0];
                set_prio(TV_LB[v], TV_PB[v]);
            end
            do_capture(TV_CLS[v][0]);
            check_class("R2/R3/R4/R5 table", TV_CLS[v][0], TV_EXP[v], TV_FND[v][0]);
        end

        // R1: a masked line with better urgency loses
        clear_inputs();
        pend[20] = 1'b1; set_prio(20, 0); mask[20] = 1'b1;
        pend[50] = 1'b1; set_prio(50, 9);
        do_capture(1'b0);
        check_class("R1 mask", 1'b0, 50, 1'b1);

        // R1: a line routed to the other class loses
        route[50] = 1'b1;
        pend[7] = 1'b1; set_prio(7, 20);
        do_capture(1'b0);
        check_class("R1 routing", 1'b0, 7, 1'b1);
        do_capture(1'b1);
        check_class("R1 routing fast", 1'b1, 50, 1'b1);

        // R3/R6: all lines pending at equal urgency -> top line of last bank
        pend = '1; route = '1; prio = '0;
        do_capture(1'b1);
        check_class("R3 R6 all lines", 1'b1, N - 1, 1'b1);

        // R7: no strobe, inputs change, registers hold
        saved_c = int'(code_fast);
        clear_inputs();
        pend[3] = 1'b1; route[3] = 1'b1; set_prio(3, 0);
        repeat (3) @(negedge clk);
        check("R7 hold code", int'(code_fast), saved_c);
        check("R7 hold flag", int'(found_fast), 1);

        // R8: normal capture leaves fast untouched
        saved_c = int'(code_fast);
        saved_f = found_fast;
        pend[90] = 1'b1; route[90] = 1'b0; set_prio(90, 1);
        do_capture(1'b0);
        check_class("R8 normal side", 1'b0, 90, 1'b1);
        check("R8 fast code kept", int'(code_fast), saved_c);
        check("R8 fast flag kept", int'(found_fast), int'(saved_f));

        // R5: empty capture clears code and flag
        clear_inputs();
        do_capture(1'b0);
        check_class("R5 empty clears", 1'b0, 0, 1'b0);

        // Random comparison against the reference scan (R1..R4)
        for (int r = 0; r < 300; r++) begin
            bit cls;
            cls = 1'(r);
            for (int w = 0; w < N; w += 32) begin
                pend[w +: 32]  = $urandom();
                mask[w +: 32]  = $urandom() | $urandom();
                route[w +: 32] = $urandom();
            end
            if (r % 17 == 0) mask = '1;
            for (int i = 0; i < N; i++) set_prio(i, $urandom_range(0, 3));
            ref_pick(cls, rf, rc);
            do_capture(cls);
            check_class("R1-R4 random", cls, rc, rf);
        end

        if (!timed_out) begin
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule